// File: doc/BRIEF.md
# Multiplexed-Address Byte RAM with Refresh Deadline Monitor

This block is a clocked behavioural model of a byte-wide memory arranged as rows and columns. The memory is reached over a single shared address bus. A controller first places the row half of the address on the bus and pulls the active-low row strobe down. It then places the column half on the same bus and pulls the active-low column strobe down. Writes and reads act on whole bytes. The chip select and write enable inputs are also active low: a column access with write enable low stores the write-data byte, and any other column access returns a byte on the read-data bus with a one-cycle valid flag.

While the row strobe stays low, the controller can issue any number of further column strobes. Each one completes without sending the row again. A falling row strobe also counts as a refresh of the row it selects. Each row has an age counter. A flag is raised when any row has gone longer than a parameterised deadline without a refresh. Both the bus and the deadline default to the full-size part, with a 10-bit bus and 2^20 locations. The number of row and column bits that reach the storage is set by parameters so that the model stays small in simulation. Address bits above those counts are ignored.

Top module: `rcmux_ram`

## Requirements
- R1: After reset, `rvalid`, `prot_err` and `refresh_viol` are 0.
- R2: The strobes are sampled on the rising clock edge. When a low row strobe follows a high sample with `cs_n` low, the block latches the low ROW_USED bits of `addr` as the row. When a low column strobe follows a high sample, the block takes the low COL_USED bits of `addr` as the column. The location accessed is at row-major index row*2^COL_USED + column.
- R3: A valid column access with `we_n` = 0 stores `wdata` at the location. It does not raise `rvalid`.
- R4: A valid column access with `we_n` = 1 drives the byte stored at the location on `rdata`. In the same cycle, `rvalid` is 1. This cycle starts one clock edge after the edge that sampled the column strobe low. `rvalid` lasts one cycle.
- R5: Page mode works while the row strobe stays low. Each new column strobe falling edge accesses the latched row at the new column, and the row is not sent again.
- R6: A column strobe falling edge with no open row is ignored. An open row exists only when a row strobe falling edge was sampled in an earlier cycle and the row strobe has stayed low. In the next cycle, `prot_err` is 1 for exactly one cycle. This includes a row strobe and column strobe that fall on the same edge.
- R7: While `cs_n` is 1, strobe falling edges are ignored. A column strobe changes no memory and raises neither `rvalid` nor `prot_err`. A row strobe latches no row, so a later column strobe is a protocol error.
- R8: A row strobe falling edge with `cs_n` low refreshes the selected row and resets its age to zero.
- R9: `refresh_viol` is 1 exactly while some row has gone REFRESH_CYCLES or more clock edges without a refresh. Reset counts as a refresh of every row.
- R10: A high sample of the row strobe closes the open row. Any later column strobe is a protocol error until the row strobe falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable, examined at the column strobe falling edge |
| addr | input | ADDR_W (10) | Shared row/column address bus |
| wdata | input | DATA_W (8) | Byte to store on a write |
| rdata | output | DATA_W (8) | Byte returned by the last read |
| rvalid | output | 1 | One-cycle pulse marking `rdata` as fresh |
| prot_err | output | 1 | One-cycle pulse for a column strobe without an open row |
| refresh_viol | output | 1 | High while any row is past its refresh deadline |

## Verification
The assertions assume that a strobe only counts as falling when the previous sample was high. They also assume that read data and the valid flag are produced only by a column strobe sampled low under chip select. The bench therefore drives every input on the falling clock edge and holds it for at least one full cycle. This way, each strobe edge is sampled exactly once. Every column strobe is returned high before the next one, so each access yields a single pulse. In the reduced 16x16 configuration, the bench writes every location and then reads every location back. It refreshes rows only through row strobes, so the age counters see only the deadlines the bench intends.

// File: rtl/rcram_pkg.sv
package rcram_pkg;

   // Outcome of a sampled column strobe edge
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_ERR   = 2'd3
   } acc_e;

endpackage

// File: rtl/rcram_strobe.sv
module rcram_strobe
   import rcram_pkg::*;
#(
   parameter int ROW_USED = 5,
   parameter int COL_USED = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic [ROW_USED-1:0] row_addr,
   input  logic [COL_USED-1:0] col_addr,
   output acc_e                acc_kind,
   output logic [ROW_USED-1:0] acc_row,
   output logic [COL_USED-1:0] acc_col,
   output logic                ref_pulse,
   output logic [ROW_USED-1:0] ref_row,
   output logic                prot_err
);

   logic                ras_q;
   logic                cas_q;
   logic                row_open;
   logic [ROW_USED-1:0] row_q;
   logic                ras_fall;
   logic                cas_fall;

   assign ras_fall = !cs_n && !ras_n && ras_q;
   assign cas_fall = !cs_n && !cas_n && cas_q;

   // strobe history, tracked regardless of chip select
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
      end
   end

   // row latch and open-row state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_open <= 1'b0;
         row_q    <= '0;
      end else begin
         if (ras_n) begin
            row_open <= 1'b0;
         end else if (ras_fall) begin
            row_open <= 1'b1;
            row_q    <= row_addr;
         end
      end
   end

   always_comb begin
      acc_kind = ACC_NONE;
      if (cas_fall) begin
         if (row_open && !ras_n) acc_kind = we_n ? ACC_READ : ACC_WRITE;
         else                    acc_kind = ACC_ERR;
      end
   end

   assign acc_row   = row_q;
   assign acc_col   = col_addr;
   assign ref_pulse = ras_fall;
   assign ref_row   = row_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) prot_err <= 1'b0;
      else        prot_err <= (acc_kind == ACC_ERR);
   end

   AST_ROW_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      row_open |-> !$past(ras_n)); // R10

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err |=> !prot_err); // R6

endmodule

// File: rtl/rcram_array.sv
module rcram_array
   import rcram_pkg::*;
#(
   parameter int ROW_USED = 5,
   parameter int COL_USED = 5,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  acc_e                acc_kind,
   input  logic [ROW_USED-1:0] acc_row,
   input  logic [COL_USED-1:0] acc_col,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                rvalid
);

   localparam int IDX_W = ROW_USED + COL_USED;
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx;

   assign idx = {acc_row, acc_col};

   always_ff @(posedge clk) begin
      if (acc_kind == ACC_WRITE) mem[idx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= (acc_kind == ACC_READ);
         if (acc_kind == ACC_READ) rdata <= mem[idx];
      end
   end

   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid); // R4

endmodule

// File: rtl/rcram_refresh.sv
module rcram_refresh #(
   parameter int ROW_USED       = 5,
   parameter int REFRESH_CYCLES = 800000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_pulse,
   input  logic [ROW_USED-1:0] ref_row,
   output logic                refresh_viol
);

   localparam int ROWS  = 1 << ROW_USED;
   localparam int AGE_W = $clog2(REFRESH_CYCLES + 1);
   localparam logic [AGE_W-1:0] LIM = AGE_W'(REFRESH_CYCLES);

   logic [ROWS-1:0] over;

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      logic [AGE_W-1:0] age;
      always_ff @(posedge clk) begin
         if (!rst_n)                                          age <= '0;
         else if (ref_pulse && (ref_row == ROW_USED'(g)))     age <= '0;
         else if (age != LIM)                                 age <= age + 1'b1;
      end
      assign over[g] = (age == LIM);
   end

   assign refresh_viol = |over;

   // independent count of edges since reset, for the deadline check
   logic [AGE_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != LIM) since_rst <= since_rst + 1'b1;
   end

   AST_VIOL_AFTER_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_viol |-> (since_rst == LIM)); // R9

endmodule

// File: rtl/rcmux_ram.sv
module rcmux_ram
   import rcram_pkg::*;
#(
   parameter int ADDR_W         = 10,
   parameter int DATA_W         = 8,
   parameter int ROW_USED       = 5,
   parameter int COL_USED       = 5,
   parameter int REFRESH_CYCLES = 800000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              prot_err,
   output logic              refresh_viol
);

   localparam int USED_MAX = (ROW_USED > COL_USED) ? ROW_USED : COL_USED;

   // elaboration-time parameter checks
   if (ROW_USED < 1 || ROW_USED > ADDR_W) begin : g_bad_row
      initial $error("rcmux_ram: ROW_USED out of range");
   end
   if (COL_USED < 1 || COL_USED > ADDR_W) begin : g_bad_col
      initial $error("rcmux_ram: COL_USED out of range");
   end
   if (ROW_USED + COL_USED > 16) begin : g_bad_depth
      initial $error("rcmux_ram: storage too deep for a model");
   end
   if (REFRESH_CYCLES < 2) begin : g_bad_limit
      initial $error("rcmux_ram: REFRESH_CYCLES must be at least 2");
   end

   // bus bits above the modelled row/column width carry no meaning here
   if (ADDR_W > USED_MAX) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:USED_MAX];
   end

   acc_e                acc_kind;
   logic [ROW_USED-1:0] acc_row;
   logic [COL_USED-1:0] acc_col;
   logic                ref_pulse;
   logic [ROW_USED-1:0] ref_row;

   rcram_strobe #(
      .ROW_USED (ROW_USED),
      .COL_USED (COL_USED)
   ) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .row_addr  (addr[ROW_USED-1:0]),
      .col_addr  (addr[COL_USED-1:0]),
      .acc_kind  (acc_kind),
      .acc_row   (acc_row),
      .acc_col   (acc_col),
      .ref_pulse (ref_pulse),
      .ref_row   (ref_row),
      .prot_err  (prot_err)
   );

   rcram_array #(
      .ROW_USED (ROW_USED),
      .COL_USED (COL_USED),
      .DATA_W   (DATA_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_kind (acc_kind),
      .acc_row  (acc_row),
      .acc_col  (acc_col),
      .wdata    (wdata),
      .rdata    (rdata),
      .rvalid   (rvalid)
   );

   rcram_refresh #(
      .ROW_USED       (ROW_USED),
      .REFRESH_CYCLES (REFRESH_CYCLES)
   ) u_refresh (
      .clk          (clk),
      .rst_n        (rst_n),
      .ref_pulse    (ref_pulse),
      .ref_row      (ref_row),
      .refresh_viol (refresh_viol)
   );

   AST_READ_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(!cs_n && !cas_n && we_n)); // R4

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_n && !cas_n && !we_n) |-> !rvalid); // R3

   AST_CS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> (!rvalid && !prot_err)); // R7

   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rvalid && prot_err)); // R6

endmodule

// File: tb/rcmux_ram_tb.sv
module rcmux_ram_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 10;
   localparam int DATA_W     = 8;
   localparam int ROW_USED   = 4;
   localparam int COL_USED   = 4;
   localparam int LIMIT      = 2000;
   localparam int ROWS       = 1 << ROW_USED;
   localparam int COLS       = 1 << COL_USED;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cs_n, ras_n, cas_n, we_n;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] rdata;
   logic              rvalid, prot_err, refresh_viol;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcmux_ram #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .ROW_USED (ROW_USED),
      .COL_USED (COL_USED), .REFRESH_CYCLES (LIMIT)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
      .we_n (we_n), .addr (addr), .wdata (wdata), .rdata (rdata),
      .rvalid (rvalid), .prot_err (prot_err), .refresh_viol (refresh_viol)
   );

   function automatic logic [7:0] pat(input int r, input int c);
      return 8'((r * 37 + c * 11 + 92) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ras_open(input int row);
      @(negedge clk);
      ras_n = 1'b0; addr = ADDR_W'(row);
   endtask

   task automatic ras_close();
      @(negedge clk);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic cas_write(input int col, input logic [7:0] d);
      @(negedge clk);
      cas_n = 1'b0; we_n = 1'b0; addr = ADDR_W'(col); wdata = d;
      @(negedge clk);
      cas_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic cas_read(input int col, output logic [7:0] d, output logic v,
                           output logic e);
      @(negedge clk);
      cas_n = 1'b0; we_n = 1'b1; addr = ADDR_W'(col);
      @(negedge clk);
      d = rdata; v = rvalid; e = prot_err;
      cas_n = 1'b1;
   endtask

   task automatic read_at(input int row, input int col, input string req,
                          input logic [7:0] exp);
      logic [7:0] d; logic v; logic e;
      ras_close();
      ras_open(row);
      cas_read(col, d, v, e);
      chk(v === 1'b1, req, int'(v), 1);
      chk(d === exp, req, int'(d), int'(exp));
      ras_close();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d; logic v; logic e;
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(rvalid === 1'b0, "R1 rvalid", int'(rvalid), 0);
      chk(prot_err === 1'b0, "R1 prot_err", int'(prot_err), 0);
      chk(refresh_viol === 1'b0, "R1 refresh_viol", int'(refresh_viol), 0);

      // R2 R3 R5: write every location, one row strobe per row (page mode)
      for (int r = 0; r < ROWS; r++) begin
         ras_open(r);
         for (int c = 0; c < COLS; c++) begin
            cas_write(c, pat(r, c));
            chk(rvalid === 1'b0, "R3 no rvalid on write", int'(rvalid), 0);
         end
         ras_close();
      end

      // R2 R4 R5: read back every location in page mode
      for (int r = 0; r < ROWS; r++) begin
         ras_open(r);
         for (int c = COLS - 1; c >= 0; c--) begin
            cas_read(c, d, v, e);
            chk(v === 1'b1, "R4 rvalid", int'(v), 1);
            chk(d === pat(r, c), "R5 page read", int'(d), int'(pat(r, c)));
         end
         @(negedge clk);
         chk(rvalid === 1'b0, "R4 rvalid one cycle", int'(rvalid), 0);
         ras_close();
      end

      // R2: upper bus bits ignored, row 3 col 9 via aliased addresses
      ras_open(3 + 16 * 5);
      cas_read(9 + 16 * 2, d, v, e);
      chk(d === pat(3, 9), "R2 address slice", int'(d), int'(pat(3, 9)));
      ras_close();

      // R6: column strobe with row strobe high
      @(negedge clk);
      cas_n = 1'b0; we_n = 1'b0; addr = 10'd3; wdata = 8'hAA;
      @(negedge clk);
      chk(prot_err === 1'b1, "R6 err no row", int'(prot_err), 1);
      chk(rvalid === 1'b0, "R6 no rvalid", int'(rvalid), 0);
      cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      chk(prot_err === 1'b0, "R6 err one cycle", int'(prot_err), 0);
      read_at(15, 3, "R6 stale row untouched", pat(15, 3));
      read_at(3, 3, "R6 row3 untouched", pat(3, 3));

      // R6: both strobes fall on the same edge
      @(negedge clk);
      ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; addr = 10'd5; wdata = 8'h11;
      @(negedge clk);
      chk(prot_err === 1'b1, "R6 simultaneous strobes", int'(prot_err), 1);
      ras_close();
      read_at(5, 5, "R6 simultaneous no write", pat(5, 5));

      // R10: closing the row makes a later column strobe an error
      ras_open(2);
      ras_close();
      cas_write(4, 8'h77);
      @(negedge clk);
      read_at(2, 4, "R10 closed row no write", pat(2, 4));
      ras_open(2);
      ras_close();
      @(negedge clk);
      cas_n = 1'b0; we_n = 1'b1; addr = 10'd4;
      @(negedge clk);
      chk(prot_err === 1'b1, "R10 err after close", int'(prot_err), 1);
      cas_n = 1'b1;

      // R7: chip select high during a column write and read
      ras_open(6);
      @(negedge clk);
      cs_n = 1'b1;
      cas_write(7, 8'h5A);
      chk(rvalid === 1'b0, "R7 no rvalid", int'(rvalid), 0);
      chk(prot_err === 1'b0, "R7 no err", int'(prot_err), 0);
      cas_read(7, d, v, e);
      chk(v === 1'b0, "R7 read ignored", int'(v), 0);
      @(negedge clk);
      cs_n = 1'b0;
      cas_read(7, d, v, e);
      chk(d === pat(6, 7), "R7 data unchanged", int'(d), int'(pat(6, 7)));
      ras_close();
      // R7: row strobe under chip select high latches nothing
      @(negedge clk);
      cs_n = 1'b1;
      ras_open(9);
      @(negedge clk);
      cs_n = 1'b0;
      cas_read(1, d, v, e);
      chk(e === 1'b1, "R7 row strobe ignored", int'(e), 1);
      chk(v === 1'b0, "R7 row strobe ignored rvalid", int'(v), 0);
      ras_close();

      // R9: no false alarm while rows were refreshed through the run
      @(negedge clk);
      chk(refresh_viol === 1'b0, "R9 no alarm", int'(refresh_viol), 0);

      // R9 R8: deadline from reset, then refresh clears it
      do_reset();
      repeat (LIMIT - 1) @(posedge clk);
      @(negedge clk);
      chk(refresh_viol === 1'b0, "R9 before deadline", int'(refresh_viol), 0);
      @(posedge clk);
      @(negedge clk);
      chk(refresh_viol === 1'b1, "R9 at deadline", int'(refresh_viol), 1);
      for (int r = 1; r < ROWS; r++) begin
         ras_open(r);
         ras_close();
      end
      @(negedge clk);
      chk(refresh_viol === 1'b1, "R8 row0 still stale", int'(refresh_viol), 1);
      ras_open(0);
      @(negedge clk);
      chk(refresh_viol === 1'b0, "R8 refresh clears", int'(refresh_viol), 0);
      ras_close();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule